// File: doc/BRIEF.md
# Three-Bank Acquisition Buffer Controller

This block keeps sample acquisition running without a break while earlier blocks are still being worked on. The acquisition side pushes fixed-length blocks of samples (128 by default) in the sample-clock domain. Each completed block lands in one of three buffer banks. The processing side runs in a separate, faster system-clock domain. It reads a completed block out of its bank, marks it processed, and later marks it transmitted. Only after it has been transmitted does the bank go back to the acquisition side. At any moment one bank can be filling, one being processed and one held for transmission, so each of the three stages gets a full block period.

Bank fill and bank release events cross between the two clocks as per-bank toggle signals. Each toggle goes through a two-flop synchronizer and an edge detector. Banks are filled and handed over in strict rotation. If the acquisition side reaches the start of a block and the bank that is next in rotation has not yet been released, the whole block is discarded. The bank keeps its contents and a sticky overrun flag is raised. The storage is a plain behavioural dual-clock RAM with a registered read port.

Top module: `acq_bank_rotator`

## Requirements
- R1: While reset is asserted and immediately after it, `overrun`, `proc_avail` and `tx_avail` are 0, and `proc_bank` and `tx_bank` are 0.
- R2: Each `wr_clk` cycle with `wr_valid` high takes one sample. Sample n of a block (n = 0 to BLK_LEN-1, counting only valid cycles, idle cycles allowed anywhere) is stored at index n of the bank being filled.
- R3: Accepted blocks go to banks 0, 1, 2, 0, ... in order. The processing side is offered them in exactly that order, with `proc_bank` giving the bank number.
- R4: `rd_data` shows the sample stored at index `rd_addr` of bank `proc_bank`, one `rd_clk` cycle after `rd_addr` is applied.
- R5: A `proc_done` pulse while `proc_avail` is 1 moves that bank to the transmit role: `tx_avail` goes to 1 with `tx_bank` naming it. The processing pointer then moves to the next bank. A bank never holds both roles at once.
- R6: A `tx_done` pulse while `tx_avail` is 1 releases that bank back to the acquisition side, clears its transmit role, and moves the transmit pointer to the next bank.
- R7: A bank that has not been released is never written. A block whose first sample arrives while the next bank in rotation is still held is discarded in full, and the held contents stay intact.
- R8: `overrun` rises one `wr_clk` cycle after the first sample of a discarded block and stays high until reset.
- R9: A `proc_done` pulse while `proc_avail` is 0 has no effect, and neither does a `tx_done` pulse while `tx_avail` is 0. Neither pointer moves.
- R10: When processing and transmission each finish within one block period, back-to-back blocks with no idle cycle between them are all accepted and `overrun` stays 0.
- R11: After a discarded block, the next accepted block goes into the same bank the discarded one was refused. The rotation order is therefore unbroken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Sample-domain clock |
| rd_clk | input | 1 | System-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain synchronously |
| wr_valid | input | 1 | A sample is present on `wr_data` this cycle |
| wr_data | input | DW | Sample value |
| overrun | output | 1 | Sticky: a block was discarded for lack of a free bank |
| rd_addr | input | IW | Sample index to read from the bank under processing |
| rd_data | output | DW | Registered read data |
| proc_avail | output | 1 | A filled bank is waiting for processing |
| proc_bank | output | BW | Bank currently offered for processing |
| proc_done | input | 1 | Pulse: processing of `proc_bank` finished |
| tx_avail | output | 1 | A processed bank is waiting for transmission |
| tx_bank | output | BW | Bank currently held for transmission |
| tx_done | input | 1 | Pulse: transmission of `tx_bank` finished, release it |

## Verification
The assertions check several properties on every cycle: no write ever lands in a bank the acquisition side still counts as held, the overrun flag never clears, the processing and transmit roles never name the same bank, both pointers step by exactly one bank on an accepted done, and done pulses with nothing available leave the pointers where they were. Only the bench scenarios can show the rest. Block contents must survive intact while later blocks are refused. The order of blocks must match across the clock crossing. Stalling either the process or the transmit stage must cause a discard at exactly the fourth outstanding block. Streaming with no idle cycles must lose nothing when the consumer keeps up.

// File: rtl/acqbuf_pkg.sv
package acqbuf_pkg;

  // Role a bank plays, as seen from the system-clock side.
  typedef enum logic [1:0] {
    BK_EMPTY = 2'd0,  // owned by the acquisition side
    BK_PROC  = 2'd1,  // filled, awaiting or under processing
    BK_SEND  = 2'd2   // processed, held for transmission
  } bank_role_e;

endpackage

// File: rtl/acqbuf_rst_sync.sv
module acqbuf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/acqbuf_tgl_sync.sv
module acqbuf_tgl_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_i,
  output logic pulse_o
);

  // two synchronizing flops plus one history flop for edge detection
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 3'b000;
    else        sh_q <= {sh_q[1:0], tgl_i};
  end

  assign pulse_o = sh_q[2] ^ sh_q[1];

endmodule

// File: rtl/acqbuf_wr_ctrl.sv
module acqbuf_wr_ctrl #(
  parameter int NBANK   = 3,
  parameter int BLK_LEN = 128,
  localparam int BW     = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int IW     = $clog2(BLK_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid_i,
  input  logic [NBANK-1:0] rel_pulse_i,
  output logic [NBANK-1:0] full_tgl_o,
  output logic             ram_we_o,
  output logic [BW-1:0]    ram_bank_o,
  output logic [IW-1:0]    ram_idx_o,
  output logic [NBANK-1:0] busy_o,
  output logic             overrun_o
);

  logic [BW-1:0]    bank_q, bank_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic             acc_q, acc_d;
  logic [NBANK-1:0] busy_q, busy_d;
  logic [NBANK-1:0] tgl_q, tgl_d;
  logic             ovr_q, ovr_d;
  logic             first, last, take;

  always_comb begin
    first  = (idx_q == '0);
    last   = (idx_q == IW'(BLK_LEN - 1));
    take   = first ? !busy_q[bank_q] : acc_q;
    bank_d = bank_q;
    idx_d  = idx_q;
    acc_d  = acc_q;
    tgl_d  = tgl_q;
    ovr_d  = ovr_q;
    busy_d = busy_q & ~rel_pulse_i;
    if (wr_valid_i) begin
      idx_d = last ? '0 : idx_q + 1'b1;
      if (first) begin
        acc_d = take;
        if (!take) ovr_d = 1'b1;
      end
      if (last && take) begin
        busy_d[bank_q] = 1'b1;
        tgl_d[bank_q]  = ~tgl_q[bank_q];
        bank_d         = (bank_q == BW'(NBANK - 1)) ? '0 : bank_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      idx_q  <= '0;
      acc_q  <= 1'b0;
      busy_q <= '0;
      tgl_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      bank_q <= bank_d;
      idx_q  <= idx_d;
      acc_q  <= acc_d;
      busy_q <= busy_d;
      tgl_q  <= tgl_d;
      ovr_q  <= ovr_d;
    end
  end

  assign ram_we_o   = wr_valid_i && take;
  assign ram_bank_o = bank_q;
  assign ram_idx_o  = idx_q;
  assign full_tgl_o = tgl_q;
  assign busy_o     = busy_q;
  assign overrun_o  = ovr_q;

endmodule

// File: rtl/acqbuf_rd_ctrl.sv
module acqbuf_rd_ctrl
  import acqbuf_pkg::*;
#(
  parameter int NBANK = 3,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] full_pulse_i,
  input  logic             proc_done_i,
  input  logic             tx_done_i,
  output logic [NBANK-1:0] rel_tgl_o,
  output logic             proc_avail_o,
  output logic [BW-1:0]    proc_bank_o,
  output logic             tx_avail_o,
  output logic [BW-1:0]    tx_bank_o
);

  bank_role_e       role_q [NBANK];
  bank_role_e       role_d [NBANK];
  logic [BW-1:0]    pp_q, pp_d, tp_q, tp_d;
  logic [NBANK-1:0] tgl_q, tgl_d;
  logic             p_av, t_av;

  always_comb begin
    role_d = role_q;
    pp_d   = pp_q;
    tp_d   = tp_q;
    tgl_d  = tgl_q;
    p_av   = (role_q[pp_q] == BK_PROC);
    t_av   = (role_q[tp_q] == BK_SEND);
    for (int b = 0; b < NBANK; b++) begin
      if (full_pulse_i[b]) role_d[b] = BK_PROC;
    end
    if (proc_done_i && p_av) begin
      role_d[pp_q] = BK_SEND;
      pp_d         = (pp_q == BW'(NBANK - 1)) ? '0 : pp_q + 1'b1;
    end
    if (tx_done_i && t_av) begin
      role_d[tp_q] = BK_EMPTY;
      tgl_d[tp_q]  = ~tgl_q[tp_q];
      tp_d         = (tp_q == BW'(NBANK - 1)) ? '0 : tp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) role_q[b] <= BK_EMPTY;
      pp_q  <= '0;
      tp_q  <= '0;
      tgl_q <= '0;
    end else begin
      role_q <= role_d;
      pp_q   <= pp_d;
      tp_q   <= tp_d;
      tgl_q  <= tgl_d;
    end
  end

  assign rel_tgl_o    = tgl_q;
  assign proc_avail_o = p_av;
  assign proc_bank_o  = pp_q;
  assign tx_avail_o   = t_av;
  assign tx_bank_o    = tp_q;

endmodule

// File: rtl/acqbuf_ram.sv
module acqbuf_ram #(
  parameter int DEPTH = 384,
  parameter int DW    = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/acq_bank_rotator.sv
module acq_bank_rotator #(
  parameter int NBANK   = 3,
  parameter int BLK_LEN = 128,
  parameter int DW      = 10,
  localparam int BW     = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int IW     = $clog2(BLK_LEN)
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          overrun,
  input  logic [IW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          proc_avail,
  output logic [BW-1:0] proc_bank,
  input  logic          proc_done,
  output logic          tx_avail,
  output logic [BW-1:0] tx_bank,
  input  logic          tx_done
);

  localparam int DEPTH = NBANK * BLK_LEN;
  localparam int AW    = $clog2(DEPTH);

  logic             wr_rst_n, rd_rst_n;
  logic [NBANK-1:0] full_tgl, full_pulse, rel_tgl, rel_pulse, wr_busy;
  logic             wr_we;
  logic [BW-1:0]    wr_bank;
  logic [IW-1:0]    wr_idx;
  logic [AW-1:0]    wr_addr, rd_full_addr;

  acqbuf_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .rst_n_o(wr_rst_n));
  acqbuf_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .rst_n_o(rd_rst_n));

  acqbuf_wr_ctrl #(.NBANK(NBANK), .BLK_LEN(BLK_LEN)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_valid_i(wr_valid),
    .rel_pulse_i(rel_pulse), .full_tgl_o(full_tgl), .ram_we_o(wr_we),
    .ram_bank_o(wr_bank), .ram_idx_o(wr_idx), .busy_o(wr_busy),
    .overrun_o(overrun)
  );

  acqbuf_rd_ctrl #(.NBANK(NBANK)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .full_pulse_i(full_pulse),
    .proc_done_i(proc_done), .tx_done_i(tx_done), .rel_tgl_o(rel_tgl),
    .proc_avail_o(proc_avail), .proc_bank_o(proc_bank),
    .tx_avail_o(tx_avail), .tx_bank_o(tx_bank)
  );

  // one toggle crossing per bank and per direction
  for (genvar b = 0; b < NBANK; b++) begin : g_cdc
    acqbuf_tgl_sync u_full (.clk(rd_clk), .rst_n(rd_rst_n),
                            .tgl_i(full_tgl[b]), .pulse_o(full_pulse[b]));
    acqbuf_tgl_sync u_rel  (.clk(wr_clk), .rst_n(wr_rst_n),
                            .tgl_i(rel_tgl[b]), .pulse_o(rel_pulse[b]));
  end

  assign wr_addr      = AW'(wr_bank) * AW'(BLK_LEN) + AW'(wr_idx);
  assign rd_full_addr = AW'(proc_bank) * AW'(BLK_LEN) + AW'(rd_addr);

  acqbuf_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .wclk(wr_clk), .we(wr_we), .waddr(wr_addr), .wdata(wr_data),
    .rclk(rd_clk), .raddr(rd_full_addr), .rdata(rd_data)
  );

endmodule

// File: rtl/acq_bank_rotator_chk.sv
module acq_bank_rotator_chk #(
  parameter int NBANK = 3,
  parameter int BW    = 2
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             rst_n,
  input logic             ram_we,
  input logic [NBANK-1:0] wr_busy,
  input logic [BW-1:0]    wr_bank,
  input logic             overrun,
  input logic             proc_avail,
  input logic [BW-1:0]    proc_bank,
  input logic             proc_done,
  input logic             tx_avail,
  input logic [BW-1:0]    tx_bank,
  input logic             tx_done
);

  function automatic logic [BW-1:0] nxt(input logic [BW-1:0] b);
    return (b == BW'(NBANK - 1)) ? '0 : b + 1'b1;
  endfunction

  a_r7_no_write_held: assert property (@(posedge wr_clk) disable iff (!rst_n)
    ram_we |-> !wr_busy[wr_bank]);

  a_r8_overrun_sticky: assert property (@(posedge wr_clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r5_roles_distinct: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (proc_avail && tx_avail) |-> (proc_bank != tx_bank));

  a_r3_proc_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (proc_done && proc_avail) |=> (proc_bank == nxt($past(proc_bank))));

  a_r6_tx_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (tx_done && tx_avail) |=> (tx_bank == nxt($past(tx_bank))));

  a_r9_proc_ignored: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (proc_done && !proc_avail) |=> $stable(proc_bank));

  a_r9_tx_ignored: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (tx_done && !tx_avail) |=> $stable(tx_bank));

endmodule

bind acq_bank_rotator acq_bank_rotator_chk #(.NBANK(NBANK), .BW(BW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ram_we(wr_we),
  .wr_busy(wr_busy), .wr_bank(wr_bank), .overrun(overrun),
  .proc_avail(proc_avail), .proc_bank(proc_bank), .proc_done(proc_done),
  .tx_avail(tx_avail), .tx_bank(tx_bank), .tx_done(tx_done)
);

// File: tb/acq_bank_rotator_tb.sv
`timescale 1ns/1ps
module acq_bank_rotator_tb;

  localparam int NB = 3, LEN = 128, DW = 10, IW = 7, BW = 2;

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [IW-1:0] rd_addr = '0;
  logic overrun, proc_avail, tx_avail;
  logic [DW-1:0] rd_data;
  logic [BW-1:0] proc_bank, tx_bank;
  logic pd_t = 1'b0, pd_m = 1'b0, td_t = 1'b0, td_m = 1'b0;
  logic proc_done, tx_done;
  assign proc_done = pd_t | pd_m;
  assign tx_done   = td_t | td_m;

  always #10 wr_clk = ~wr_clk;                   // 50 MHz sample clock
  initial begin #1; forever #2.5 rd_clk = ~rd_clk; end  // 200 MHz system clock

  acq_bank_rotator u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_data(wr_data), .overrun(overrun), .rd_addr(rd_addr), .rd_data(rd_data),
    .proc_avail(proc_avail), .proc_bank(proc_bank), .proc_done(proc_done),
    .tx_avail(tx_avail), .tx_bank(tx_bank), .tx_done(tx_done)
  );

  int checks = 0, errors = 0;
  int acc_cnt = 0, rel_cnt = 0, proc_cnt = 0;
  int tagq[$];
  bit exp_ovr = 1'b0, run_cmp = 1'b0, proc_hold = 1'b1, tx_hold = 1'b1;
  string req_tag = "R4";
  int p_tag, p_bad, p_act, p_exp;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // reference model: accept iff fewer than NB blocks are held downstream
  task automatic send_block(input int tag, input bit gaps);
    bit acc;
    acc = (acc_cnt - rel_cnt) < NB;
    for (int i = 0; i < LEN; i++) begin
      if (gaps && (i % 4 == 2)) begin
        wr_valid = 1'b0;
        @(negedge wr_clk);
      end
      wr_valid = 1'b1;
      wr_data  = DW'((tag % 8) * LEN + i);
      @(posedge wr_clk);
      if (i == 0 && !acc) exp_ovr = 1'b1;
      if (i == LEN - 1 && acc) begin
        tagq.push_back(tag);
        acc_cnt++;
      end
      @(negedge wr_clk);
    end
  endtask

  task automatic wait_drain();
    while (rel_cnt != acc_cnt) @(negedge wr_clk);
    repeat (10) @(negedge wr_clk);
  endtask

  // overrun compared with the model on every sample clock (R8)
  always @(negedge wr_clk)
    if (run_cmp) chk(overrun == exp_ovr, "R8 overrun", overrun, exp_ovr);

  // processing consumer
  initial begin
    forever begin
      @(negedge rd_clk);
      if (rst_n && !proc_hold && proc_avail) begin
        chk(proc_bank == BW'(proc_cnt % NB), "R3 bank order", proc_bank, proc_cnt % NB);
        p_tag = tagq[proc_cnt];
        p_bad = 0;
        rd_addr = '0;
        for (int i = 0; i < LEN; i++) begin
          @(negedge rd_clk);
          if (rd_data !== DW'((p_tag % 8) * LEN + i)) begin
            if (p_bad == 0) begin
              p_act = int'(rd_data);
              p_exp = (p_tag % 8) * LEN + i;
            end
            p_bad++;
          end
          rd_addr = IW'((i + 1) % LEN);
        end
        chk(p_bad == 0, req_tag, p_act, p_exp);
        pd_t = 1'b1;
        @(negedge rd_clk);
        pd_t = 1'b0;
        proc_cnt++;
      end
    end
  end

  // transmit consumer
  initial begin
    forever begin
      @(negedge rd_clk);
      if (rst_n && !tx_hold && tx_avail) begin
        chk(tx_bank == BW'(rel_cnt % NB), "R6 tx order", tx_bank, rel_cnt % NB);
        repeat (3) @(negedge rd_clk);
        td_t = 1'b1;
        @(negedge rd_clk);
        td_t = 1'b0;
        rel_cnt++;
      end
    end
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge wr_clk);
    chk(overrun == 1'b0 && proc_avail == 1'b0 && tx_avail == 1'b0, "R1 flags in reset",
        {overrun, proc_avail, tx_avail}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    chk(proc_bank == 0 && tx_bank == 0, "R1 pointers", {proc_bank, tx_bank}, 0);
    chk(proc_avail == 1'b0 && tx_avail == 1'b0, "R1 avail", {proc_avail, tx_avail}, 0);
    run_cmp = 1'b1;

    // done pulses with nothing available
    @(negedge rd_clk);
    pd_m = 1'b1; td_m = 1'b1;
    @(negedge rd_clk);
    pd_m = 1'b0; td_m = 1'b0;
    repeat (4) @(negedge rd_clk);
    chk(proc_bank == 0 && tx_bank == 0 && !proc_avail && !tx_avail, "R9 idle done",
        {proc_bank, tx_bank}, 0);

    // streaming, no idle cycles, consumer keeps up
    proc_hold = 1'b0; tx_hold = 1'b0;
    req_tag = "R2 R4 data";
    for (int t = 0; t < 6; t++) send_block(t, 1'b0);
    wr_valid = 1'b0;
    wait_drain();
    chk(overrun == 1'b0, "R10 no overrun", overrun, 0);
    chk(proc_cnt == 6, "R10 all blocks", proc_cnt, 6);

    // idle cycles inside blocks
    req_tag = "R2 gapped data";
    send_block(6, 1'b1);
    send_block(7, 1'b1);
    wr_valid = 1'b0;
    wait_drain();

    // transmit stage stalled
    tx_hold = 1'b1;
    req_tag = "R4 data";
    send_block(1, 1'b0);
    wr_valid = 1'b0;
    while (proc_cnt != acc_cnt) @(negedge rd_clk);
    repeat (4) @(negedge rd_clk);
    chk(proc_avail == 1'b0, "R5 proc cleared", proc_avail, 0);
    chk(tx_avail == 1'b1, "R5 tx role", tx_avail, 1);
    chk(tx_bank == BW'(rel_cnt % NB), "R5 tx bank", tx_bank, rel_cnt % NB);
    pd_m = 1'b1;
    @(negedge rd_clk);
    pd_m = 1'b0;
    repeat (3) @(negedge rd_clk);
    chk(proc_bank == BW'(acc_cnt % NB), "R9 held done", proc_bank, acc_cnt % NB);
    send_block(2, 1'b0);
    send_block(3, 1'b0);
    send_block(4, 1'b0);  // no bank released: discarded
    wr_valid = 1'b0;
    @(negedge wr_clk);
    chk(overrun == 1'b1, "R8 set", overrun, 1);
    repeat (20) @(negedge wr_clk);
    tx_hold = 1'b0;
    wait_drain();
    chk(tx_avail == 1'b0, "R6 released", tx_avail, 0);

    // processing stage stalled: held contents must survive a refused block
    proc_hold = 1'b1;
    req_tag = "R4 R7 intact";
    send_block(5, 1'b0);
    send_block(6, 1'b0);
    send_block(7, 1'b0);
    send_block(0, 1'b0);  // discarded
    wr_valid = 1'b0;
    repeat (10) @(negedge wr_clk);
    chk(proc_avail == 1'b1, "R7 still offered", proc_avail, 1);
    proc_hold = 1'b0;
    wait_drain();

    // next accepted block resumes rotation in the refused bank
    req_tag = "R11 resumed data";
    send_block(1, 1'b0);
    wr_valid = 1'b0;
    wait_drain();
    chk(proc_cnt == acc_cnt, "R11 consumed", proc_cnt, acc_cnt);
    chk(overrun == 1'b1, "R8 sticky", overrun, 1);

    run_cmp = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule